// File: doc/BRIEF.md
# Host-Slave Two-Channel Byte Mailbox

This block sits between an external host processor and a local controller and lets the two exchange bytes through one or two mailbox channels. The host drives an asynchronous bus with separate active-low read and write strobes, two active-low channel selects and one address line. The address line picks either the data byte or the status byte of the selected channel. Each channel has an inbound byte, written by the host and consumed locally, and an outbound byte, produced locally and read by the host. An "inbound full" flag and an "outbound full" flag track the state of each channel.

The local side configures the block through a two-bit control word. It pushes outbound bytes through a valid/ready port and pops inbound bytes through a second valid/ready port. The local side also receives two interrupt request lines. One pulses when any channel's inbound byte becomes full. The other pulses when any channel's outbound byte is emptied by the host. The per-channel flags stay visible, so a handler can find the channel that raised a request.

Host strobes are brought into the local clock domain by a two-flop synchroniser. Each host access takes effect once, on the trailing (rising) edge of its strobe. The selects, the address line and the write data must be held steady from the strobe's assertion until four local clock cycles after its release.

Top module: `hostlink_top`

## Requirements
- R1: Control bit 0 (enable) is 0 after reset. While it is 0, host accesses change no flag and no buffer, `h_dout` reads 0, `tx_ready` is 0 and `rx_valid` is 0.
- R2: Control bit 1 (mode) selects single mode (0, channel 0 only) or double mode (1, channels 0 and 1). In single mode `h_cs1_n` is ignored and local accesses to channel 1 are refused. When both selects are low, channel 0 wins.
- R3: A host write with `h_a0`=0 loads the selected channel's inbound byte and sets its inbound-full flag. The write acts once, within four clock cycles of the write strobe rising. A host write with `h_a0`=1 changes nothing.
- R4: A host read with `h_a0`=0 returns the selected outbound byte, and the read strobe's rising edge clears that channel's outbound-full flag. A host read with `h_a0`=1 returns a status byte (bit 0 = outbound full, bit 1 = inbound full, bits 7:2 = 0) and changes no flag.
- R5: `tx_ready` is high when channel `tx_ch` is usable and its outbound-full flag is clear. A cycle with `tx_valid` and `tx_ready` both high stores `tx_data` and sets the outbound-full flag. While `tx_ready` is low, the producer holds its byte.
- R6: `rx_valid` is high when channel `rx_ch` is usable and its inbound-full flag is set, and `rx_data` is that channel's inbound byte. A cycle with `rx_valid` and `rx_ready` both high clears the flag.
- R7: `irq_ibf` is a one-cycle pulse in the cycle after any inbound-full flag rises. Rises on both channels in the same cycle merge into one pulse.
- R8: `irq_obe` is a one-cycle pulse in the cycle after any outbound-full flag falls. Falls on both channels in the same cycle merge into one pulse.
- R9: `ibf_flags[i]` and `obf_flags[i]` show channel i's inbound-full and outbound-full flags at all times.
- R10: Reset clears every flag, every buffer and both control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 2 | Control word: bit 0 enable, bit 1 double mode |
| h_cs0_n | input | 1 | Host select, channel 0, active low |
| h_cs1_n | input | 1 | Host select, channel 1, active low (double mode only) |
| h_a0 | input | 1 | Host address: 0 data, 1 status |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_din | input | DW | Host write data |
| h_dout | output | DW | Host read data |
| tx_valid | input | 1 | Local outbound byte offered |
| tx_ready | output | 1 | Outbound byte accepted this cycle if valid |
| tx_ch | input | 1 | Outbound channel index |
| tx_data | input | DW | Outbound byte |
| rx_ch | input | 1 | Inbound channel index |
| rx_valid | output | 1 | Inbound byte available |
| rx_ready | input | 1 | Local side consumes the inbound byte |
| rx_data | output | DW | Inbound byte |
| ibf_flags | output | NCH | Inbound-full flag per channel |
| obf_flags | output | NCH | Outbound-full flag per channel |
| irq_ibf | output | 1 | Merged inbound-full request pulse |
| irq_obe | output | 1 | Merged outbound-empty request pulse |

## Verification
The assertions assume the host leaves each strobe high for at least a few cycles between accesses, so that every flag edge is followed by a quiet cycle. They also assume the select, address and data lines hold steady around the trailing edge. The bench drives each strobe low for four cycles and then high for four more before it changes any select or data line, which keeps every access inside both assumptions. The bench sweeps enable, mode, channel and several byte patterns. It counts interrupt pulses on the falling clock edge, so a merged pulse must show up exactly once per flag edge.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  localparam int unsigned HL_NCH = 2;
  localparam int unsigned HL_CW  = 1;

  typedef struct packed {
    logic dual;
    logic en;
  } hl_ctl_t;

  localparam int unsigned ST_OBF_BIT = 0;
  localparam int unsigned ST_IBF_BIT = 1;
endpackage

// File: rtl/hl_strobe_sync.sv
module hl_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic trail
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], strobe_n};
  end

  // released strobe: synchronised level high, one stage older still low
  assign trail = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/hl_channel.sv
module hl_channel #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [DW-1:0] h_din,
  input  logic          l_wr,
  input  logic [DW-1:0] l_din,
  input  logic          l_rd,
  output logic [DW-1:0] in_byte,
  output logic [DW-1:0] out_byte,
  output logic          in_full,
  output logic          out_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_byte <= '0;
      in_full <= 1'b0;
    end else if (h_wr) begin
      in_byte <= h_din;
      in_full <= 1'b1;
    end else if (l_rd) begin
      in_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_byte <= '0;
      out_full <= 1'b0;
    end else if (l_wr) begin
      out_byte <= l_din;
      out_full <= 1'b1;
    end else if (h_rd) begin
      out_full <= 1'b0;
    end
  end
endmodule

// File: rtl/hl_edge_merge.sv
module hl_edge_merge #(
  parameter int unsigned NCH  = 2,
  parameter bit          IDLE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] lvl,
  output logic           pulse
);
  logic [NCH-1:0] prev;
  logic [NCH-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= {NCH{IDLE}};
    else        prev <= lvl;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_shot
    assign rise[i] = lvl[i] & ~prev[i];
  end

  assign pulse = |rise;
endmodule

// File: rtl/hostlink_top.sv
module hostlink_top
  import hostlink_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned NCH = HL_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic [1:0]     ctl_wdata,
  input  logic           h_cs0_n,
  input  logic           h_cs1_n,
  input  logic           h_a0,
  input  logic           h_rd_n,
  input  logic           h_wr_n,
  input  logic [DW-1:0]  h_din,
  output logic [DW-1:0]  h_dout,
  input  logic           tx_valid,
  output logic           tx_ready,
  input  logic           tx_ch,
  input  logic [DW-1:0]  tx_data,
  input  logic           rx_ch,
  output logic           rx_valid,
  input  logic           rx_ready,
  output logic [DW-1:0]  rx_data,
  output logic [NCH-1:0] ibf_flags,
  output logic [NCH-1:0] obf_flags,
  output logic           irq_ibf,
  output logic           irq_obe
);
  hl_ctl_t ctl_q;
  logic    ctl_en, ctl_dual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= hl_ctl_t'(ctl_wdata);
  end
  assign ctl_en   = ctl_q.en;
  assign ctl_dual = ctl_q.dual;

  logic wr_done, rd_done;
  hl_strobe_sync #(.STAGES(2)) u_wr_sync (.clk, .rst_n, .strobe_n(h_wr_n), .trail(wr_done));
  hl_strobe_sync #(.STAGES(2)) u_rd_sync (.clk, .rst_n, .strobe_n(h_rd_n), .trail(rd_done));

  logic [NCH-1:0] usable, hit;
  logic [NCH-1:0] h_wr_v, h_rd_v, l_wr_v, l_rd_v;
  logic [DW-1:0]  in_b  [NCH];
  logic [DW-1:0]  out_b [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_first
      assign usable[i] = ctl_en;
      assign hit[i]    = ctl_en & ~h_cs0_n;
    end else begin : g_rest
      assign usable[i] = ctl_en & ctl_dual;
      assign hit[i]    = ctl_en & ctl_dual & ~h_cs1_n & h_cs0_n;
    end

    assign h_wr_v[i] = wr_done & hit[i] & ~h_a0;
    assign h_rd_v[i] = rd_done & hit[i] & ~h_a0;
    assign l_wr_v[i] = tx_valid & tx_ready & (tx_ch == HL_CW'(i));
    assign l_rd_v[i] = rx_valid & rx_ready & (rx_ch == HL_CW'(i));

    hl_channel #(.DW(DW)) u_ch (
      .clk, .rst_n,
      .h_wr(h_wr_v[i]), .h_rd(h_rd_v[i]), .h_din(h_din),
      .l_wr(l_wr_v[i]), .l_din(tx_data), .l_rd(l_rd_v[i]),
      .in_byte(in_b[i]), .out_byte(out_b[i]),
      .in_full(ibf_flags[i]), .out_full(obf_flags[i])
    );
  end

  assign tx_ready = usable[tx_ch] & ~obf_flags[tx_ch];
  assign rx_valid = usable[rx_ch] &  ibf_flags[rx_ch];
  assign rx_data  = in_b[rx_ch];

  always_comb begin
    h_dout = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        if (h_a0) begin
          h_dout = '0;
          h_dout[ST_OBF_BIT] = obf_flags[i];
          h_dout[ST_IBF_BIT] = ibf_flags[i];
        end else begin
          h_dout = out_b[i];
        end
      end
    end
  end

  hl_edge_merge #(.NCH(NCH), .IDLE(1'b0)) u_ibf_irq (
    .clk, .rst_n, .lvl(ibf_flags), .pulse(irq_ibf)
  );
  hl_edge_merge #(.NCH(NCH), .IDLE(1'b1)) u_obe_irq (
    .clk, .rst_n, .lvl(~obf_flags), .pulse(irq_obe)
  );
endmodule

// File: rtl/hostlink_chk.sv
module hostlink_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctl_en,
  input logic           ctl_dual,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic           tx_ch,
  input logic [NCH-1:0] ibf_flags,
  input logic [NCH-1:0] obf_flags,
  input logic           irq_ibf,
  input logic           irq_obe
);
  assert_disabled_no_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (((ibf_flags | obf_flags) & ~$past(ibf_flags | obf_flags)) == '0));

  assert_single_ch1_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_dual |=> !((ibf_flags[1] && !$past(ibf_flags[1])) || (obf_flags[1] && !$past(obf_flags[1]))));

  assert_tx_accept_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> obf_flags[$past(tx_ch)]);

  assert_ibf_rise_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ibf_flags & ~$past(ibf_flags)) != '0) |-> irq_ibf);

  assert_irq_ibf_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ibf |=> !irq_ibf);

  assert_obf_fall_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(obf_flags) & ~obf_flags) != '0) |-> irq_obe);

  assert_irq_obe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_obe |=> !irq_obe);
endmodule

bind hostlink_top hostlink_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_dual(ctl_dual),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ch(tx_ch),
  .ibf_flags(ibf_flags), .obf_flags(obf_flags),
  .irq_ibf(irq_ibf), .irq_obe(irq_obe)
);

// File: tb/hostlink_top_tb_top.sv
`timescale 1ns/100ps
module hostlink_top_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0; logic [1:0] ctl_wdata = '0;
  logic h_cs0_n = 1'b1, h_cs1_n = 1'b1, h_a0 = 1'b0, h_rd_n = 1'b1, h_wr_n = 1'b1;
  logic [DW-1:0] h_din = '0, h_dout;
  logic tx_valid = 1'b0, tx_ready, tx_ch = 1'b0; logic [DW-1:0] tx_data = '0;
  logic rx_ch = 1'b0, rx_valid, rx_ready = 1'b0; logic [DW-1:0] rx_data;
  logic [1:0] ibf_flags, obf_flags;
  logic irq_ibf, irq_obe;

  int checks = 0, failures = 0, n_ibf = 0, n_obe = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hostlink_top #(.DW(DW)) dut_i (.*);

  always @(negedge clk) if (rst_n) begin
    if (irq_ibf) n_ibf++;
    if (irq_obe) n_obe++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ctl(input bit en, input bit dual);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = {dual, en};
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic sel(input int ch);
    h_cs0_n = (ch != 0); h_cs1_n = (ch != 1);
  endtask

  task automatic host_wr(input int ch, input bit a0, input logic [7:0] d);
    @(negedge clk); sel(ch); h_a0 = a0; h_din = d; h_wr_n = 1'b0;
    repeat (4) @(negedge clk); h_wr_n = 1'b1;
    repeat (4) @(negedge clk); h_cs0_n = 1'b1; h_cs1_n = 1'b1;
  endtask

  task automatic host_rd(input int ch, input bit a0, output logic [7:0] d);
    @(negedge clk); sel(ch); h_a0 = a0; h_rd_n = 1'b0;
    repeat (2) @(negedge clk); d = h_dout;
    repeat (2) @(negedge clk); h_rd_n = 1'b1;
    repeat (4) @(negedge clk); h_cs0_n = 1'b1; h_cs1_n = 1'b1;
  endtask

  initial begin
    logic [7:0] rd, d, td;
    int ib0, ob0;
    bit ok;
    repeat (3) @(negedge clk);
    chk(ibf_flags == 0 && obf_flags == 0, "R10 reset flags", {ibf_flags, obf_flags}, 0);
    chk(tx_ready == 0 && rx_valid == 0, "R1 reset not ready", {tx_ready, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int en = 0; en < 2; en++)
      for (int dual = 0; dual < 2; dual++)
        for (int ch = 0; ch < 2; ch++)
          for (int k = 0; k < 4; k++) begin
            ok = (en == 1) && (ch == 0 || dual == 1);
            d  = 8'((k * 53) + (ch * 17) + (en * 5) + (dual * 3) + 1);
            td = d ^ 8'hA5;
            set_ctl(en[0], dual[0]);
            ib0 = n_ibf; ob0 = n_obe;
            // R3 host write into inbound byte
            host_wr(ch, 1'b0, d);
            chk(ibf_flags == (ok ? (2'b01 << ch) : 2'b00), "R3/R9 ibf after host write", ibf_flags, ok ? (1 << ch) : 0);
            chk(n_ibf - ib0 == int'(ok), "R7 one ibf pulse", n_ibf - ib0, int'(ok));
            @(negedge clk); rx_ch = ch[0];
            #0.1;
            chk(rx_valid == ok, "R6 rx_valid", rx_valid, ok);
            if (ok) chk(rx_data == d, "R6 rx_data", rx_data, d);
            // R3 status-address write ignored
            host_wr(ch, 1'b1, ~d);
            if (ok) chk(rx_data == d && ibf_flags == (2'b01 << ch), "R3 a0 write ignored", rx_data, d);
            chk(n_ibf - ib0 == int'(ok), "R7 no pulse on ignored write", n_ibf - ib0, int'(ok));
            // R4 status read
            host_rd(ch, 1'b1, rd);
            chk(rd == (ok ? 8'h02 : 8'h00), "R4 status byte", rd, ok ? 2 : 0);
            chk(ibf_flags == (ok ? (2'b01 << ch) : 2'b00), "R4 status read keeps flags", ibf_flags, ok ? (1 << ch) : 0);
            // R6 local pop
            @(negedge clk); rx_ready = 1'b1;
            @(negedge clk); rx_ready = 1'b0;
            chk(ibf_flags == 0, "R6 pop clears ibf", ibf_flags, 0);
            // R5 local push
            @(negedge clk); tx_ch = ch[0]; tx_data = td; tx_valid = 1'b1;
            #0.1;
            chk(tx_ready == ok, "R5/R1/R2 tx_ready", tx_ready, ok);
            @(negedge clk); tx_valid = 1'b0;
            chk(obf_flags == (ok ? (2'b01 << ch) : 2'b00), "R5 obf after push", obf_flags, ok ? (1 << ch) : 0);
            #0.1;
            chk(tx_ready == 1'b0, "R5 ready low while full", tx_ready, 0);
            // R4 host data read
            host_rd(ch, 1'b0, rd);
            chk(rd == (ok ? td : 8'h00), "R4 data byte", rd, ok ? td : 0);
            chk(obf_flags == 0, "R4 read clears obf", obf_flags, 0);
            chk(n_obe - ob0 == int'(ok), "R8 one obe pulse", n_obe - ob0, int'(ok));
          end

    // R2 both selects low: channel 0 wins
    set_ctl(1'b1, 1'b1);
    @(negedge clk); h_cs0_n = 1'b0; h_cs1_n = 1'b0; h_a0 = 1'b0; h_din = 8'h3C; h_wr_n = 1'b0;
    repeat (4) @(negedge clk); h_wr_n = 1'b1;
    repeat (4) @(negedge clk); h_cs0_n = 1'b1; h_cs1_n = 1'b1;
    chk(ibf_flags == 2'b01, "R2 channel 0 priority", ibf_flags, 1);

    // R10 reset clears flags, buffers, control
    @(negedge clk); tx_ch = 1'b1; tx_data = 8'h77; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(ibf_flags == 0 && obf_flags == 0, "R10 flags cleared", {ibf_flags, obf_flags}, 0);
    host_wr(0, 1'b0, 8'h11);
    chk(ibf_flags == 0, "R10 enable cleared", ibf_flags, 0);
    set_ctl(1'b1, 1'b1);
    host_rd(1, 1'b0, rd);
    chk(rd == 8'h00, "R10 outbound buffer cleared", rd, 0);
    rx_ch = 1'b0;
    #0.1;
    chk(rx_data == 8'h00, "R10 inbound buffer cleared", rx_data, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule